// File: doc/BRIEF.md
# Per-Pin Glitch/Debounce Input Filter Bank

This block sits in a bank of general-purpose pins, between the already synchronised pad inputs and the logic that reports pin levels and raises pin interrupts. Each pin has a filter that can be switched on or off. When the filter is on, it runs in one of two modes. Fast mode rejects any level that does not stay stable for two system clocks. Slow mode rejects any level that does not stay stable across two ticks of a slow clock.

The slow clock is not a separate clock domain. It is a one-cycle tick pulse on the system clock, made by a counter whose period is set by a divider value shared by the whole bank. Software controls the block with single-cycle write strobes. Each strobe carries a command code and a data word. Four codes set or clear per-pin configuration bits, using the data word as a pin mask. The fifth code loads the divider. The filtered vector goes out on `filt_o` and is meant to feed both the level readback and the interrupt detector.

Top module: `gflt_bank`

## Requirements
- R1: After reset every filter is off, every pin is in fast mode, the divider reads 0, and `filt_o` equals `pin_i`.
- R2: A write with code 0 sets the filter-enable bit of each pin whose data bit is 1. A write with code 1 clears it. Pins whose data bit is 0 keep their bit. The result shows on `flt_en_o` after the write edge.
- R3: A write with code 2 sets the slow-mode bit of each pin whose data bit is 1. A write with code 3 clears it, which selects fast mode. Other pins keep their bit. The result shows on `deb_sel_o`.
- R4: A write with code 4 stores only the low DIV_W bits of the data word on `div_o` (all ones written gives 14'h3FFF at default). It also restarts the slow tick, so ticks act at the edges 2*(DIV+1), 4*(DIV+1) and so on after the write edge.
- R5: Codes 5, 6 and 7, and any cycle with `wr_en_i` low, leave `flt_en_o`, `deb_sel_o` and `div_o` unchanged.
- R6: For a pin whose filter is off, `filt_o` equals `pin_i` in the same cycle, with no register in the path.
- R7: In fast mode, a pin output takes a new level at the second consecutive clock edge that samples that level. A pulse that covers only one edge never reaches `filt_o`.
- R8: In slow mode, a pin output takes a new level only at a tick edge, and only when the same level was also sampled at the previous tick. Two ticks never act on consecutive edges.
- R9: In slow mode, a pulse that falls between two ticks, or that covers only one tick, leaves `filt_o` unchanged.
- R10: While a filter is off, its state follows the input. Turning the filter on for a steady input therefore causes no transition on `filt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per command |
| wr_cmd_i | input | 3 | Command code (0 on, 1 off, 2 slow, 3 fast, 4 divider) |
| wr_data_i | input | NPINS | Pin mask, or divider value in the low DIV_W bits |
| pin_i | input | NPINS | Synchronised pad levels |
| filt_o | output | NPINS | Filtered pin levels |
| flt_en_o | output | NPINS | Filter-enable bit per pin |
| deb_sel_o | output | NPINS | Slow-mode select bit per pin |
| div_o | output | DIV_W | Stored divider value |

## Verification
The assertions assume `pin_i` is already synchronous to `clk_i`, so a level seen at one edge is a clean sample. They also assume at most one write strobe per cycle, since the interface carries a single command. The bench changes `pin_i` and the write signals only on falling edges and uses one command per write. It also waits at least three cycles after reset before any checks that look two samples back. This keeps the stimulus inside those assumptions.

// File: rtl/gflt_pkg.sv
package gflt_pkg;

    // Command codes on the write strobe
    typedef enum logic [2:0] {
        CMD_FLT_ON  = 3'd0,
        CMD_FLT_OFF = 3'd1,
        CMD_SEL_DEB = 3'd2,
        CMD_SEL_GLT = 3'd3,
        CMD_DIV_WR  = 3'd4
    } cmd_e;

    // Per-pin filter state
    typedef struct packed {
        logic prev;   // input seen at the previous clock edge
        logic samp;   // input seen at the previous slow tick
        logic out;    // accepted level
    } pin_st_t;

endpackage

// File: rtl/gflt_tick.sv
module gflt_tick #(
    parameter int DIV_W = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart_i,
    output logic             tick_o
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [CNT_W-1:0] term;

    // terminal count 2*DIV+1 gives a period of 2*(DIV+1)
    assign term   = {div_i, 1'b1};
    assign tick_o = (st_q.cnt == term);

    always_comb begin
        st_d = st_q;
        if (restart_i || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/gflt_pin.sv
module gflt_pin
    import gflt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic en_i,
    input  logic deb_i,
    input  logic tick_i,
    output logic filt_o
);
    pin_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_i;
        if (!en_i) begin
            // filter off: state shadows the raw input
            st_d.out  = pin_i;
            st_d.samp = pin_i;
        end else if (!deb_i) begin
            st_d.samp = pin_i;
            if (pin_i == st_q.prev) begin
                st_d.out = pin_i;
            end
        end else if (tick_i) begin
            st_d.samp = pin_i;
            if (pin_i == st_q.samp) begin
                st_d.out = pin_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = en_i ? st_q.out : pin_i;

endmodule

// File: rtl/gflt_bank.sv
module gflt_bank
    import gflt_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DIV_W = 14
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_cmd_i,
    input  logic [NPINS-1:0] wr_data_i,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] filt_o,
    output logic [NPINS-1:0] flt_en_o,
    output logic [NPINS-1:0] deb_sel_o,
    output logic [DIV_W-1:0] div_o
);
    typedef struct packed {
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] deb;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic div_wr;
    logic slow_tick;

    assign div_wr = wr_en_i && (wr_cmd_i == CMD_DIV_WR);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (wr_cmd_i)
                CMD_FLT_ON:  cfg_d.en  = cfg_q.en | wr_data_i;
                CMD_FLT_OFF: cfg_d.en  = cfg_q.en & ~wr_data_i;
                CMD_SEL_DEB: cfg_d.deb = cfg_q.deb | wr_data_i;
                CMD_SEL_GLT: cfg_d.deb = cfg_q.deb & ~wr_data_i;
                CMD_DIV_WR:  cfg_d.div = wr_data_i[DIV_W-1:0];
                default:     cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    gflt_tick #(.DIV_W(DIV_W)) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_i     (cfg_q.div),
        .restart_i (div_wr),
        .tick_o    (slow_tick)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        gflt_pin u_pin (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pin_i  (pin_i[g]),
            .en_i   (cfg_q.en[g]),
            .deb_i  (cfg_q.deb[g]),
            .tick_i (slow_tick),
            .filt_o (filt_o[g])
        );
    end

    assign flt_en_o  = cfg_q.en;
    assign deb_sel_o = cfg_q.deb;
    assign div_o     = cfg_q.div;

endmodule

// File: rtl/gflt_chk.sv
module gflt_chk #(
    parameter int NPINS = 32,
    parameter int DIV_W = 14
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [2:0]       wr_cmd_i,
    input logic [NPINS-1:0] wr_data_i,
    input logic [NPINS-1:0] pin_i,
    input logic [NPINS-1:0] filt_o,
    input logic [NPINS-1:0] flt_en_o,
    input logic [NPINS-1:0] deb_sel_o,
    input logic [DIV_W-1:0] div_o,
    input logic             tick_i
);
    logic [1:0] arm_cnt;
    logic       armed;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            arm_cnt <= '0;
        end else if (arm_cnt != 2'd3) begin
            arm_cnt <= arm_cnt + 2'd1;
        end
    end
    assign armed = (arm_cnt == 2'd3);

    AST_BYPASS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((~flt_en_o) & (filt_o ^ pin_i)) == '0); // R6

    AST_FAST_TWO_SAMPLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed |-> ((((filt_o ^ $past(filt_o)) & $past(flt_en_o & ~deb_sel_o) & flt_en_o)
                   & ((filt_o ^ $past(pin_i)) | (filt_o ^ $past(pin_i, 2)))) == '0)); // R7

    AST_SLOW_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed && (((filt_o ^ $past(filt_o)) & $past(flt_en_o & deb_sel_o) & flt_en_o) != '0)
        |-> $past(tick_i)); // R8

    AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> !tick_i); // R8

    AST_DIV_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_cmd_i == 3'd4) |=> (div_o == $past(wr_data_i[DIV_W-1:0]))); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i || wr_cmd_i > 3'd4) |=>
        ($stable(flt_en_o) && $stable(deb_sel_o) && $stable(div_o))); // R5

endmodule

bind gflt_bank gflt_chk #(.NPINS(NPINS), .DIV_W(DIV_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_cmd_i  (wr_cmd_i),
    .wr_data_i (wr_data_i),
    .pin_i     (pin_i),
    .filt_o    (filt_o),
    .flt_en_o  (flt_en_o),
    .deb_sel_o (deb_sel_o),
    .div_o     (div_o),
    .tick_i    (slow_tick)
);

// File: tb/sim_gflt_bank.sv
module sim_gflt_bank;
    localparam int NPINS = 32;
    localparam int DIV_W = 14;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             wr_en_i = 1'b0;
    logic [2:0]       wr_cmd_i = 3'd0;
    logic [NPINS-1:0] wr_data_i = '0;
    logic [NPINS-1:0] pin_i = '0;
    logic [NPINS-1:0] filt_o, flt_en_o, deb_sel_o;
    logic [DIV_W-1:0] div_o;

    int checks = 0;
    int errors = 0;

    always #4 clk_i = ~clk_i;

    gflt_bank #(.NPINS(NPINS), .DIV_W(DIV_W)) u0 (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_cmd_i(wr_cmd_i),
        .wr_data_i(wr_data_i), .pin_i(pin_i), .filt_o(filt_o), .flt_en_o(flt_en_o),
        .deb_sel_o(deb_sel_o), .div_o(div_o)
    );

    typedef struct packed {
        logic [31:0] din;
        logic [31:0] dexp;
    } vec_t;

    localparam logic [31:0] VA = 32'hA5A5_0F0F;
    localparam logic [31:0] VB = 32'h5A5A_F0F0;
    localparam logic [31:0] VC = 32'h1234_5678;

    // fast-mode sequence: input driven, expected output after the next edge
    localparam vec_t FAST_TBL [8] = '{
        '{VA, 32'h0}, '{VA, VA}, '{VB, VA}, '{VA, VA},
        '{VC, VA},    '{VC, VC}, '{32'h0, VC}, '{32'h0, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic en, input logic [2:0] cmd, input logic [31:0] data);
        @(negedge clk_i);
        wr_en_i   = en;
        wr_cmd_i  = cmd;
        wr_data_i = data;
        @(posedge clk_i);
        @(negedge clk_i);
        wr_en_i   = 1'b0;
        wr_data_i = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        pin_i = 32'h0000_1234;
        idle(3);
        // R1: reset state, bypass active
        chk("R1 en", flt_en_o, 32'h0);
        chk("R1 deb", deb_sel_o, 32'h0);
        chk("R1 div", {18'h0, div_o}, 32'h0);
        chk("R1 filt", filt_o, 32'h0000_1234);
        rst_ni = 1'b1;
        pin_i  = '0;
        idle(3);

        // R2: set/clear of enable bits
        wr(1'b1, 3'd0, 32'h0000_000F);
        wr(1'b1, 3'd0, 32'h0000_00F0);
        chk("R2 set", flt_en_o, 32'h0000_00FF);
        wr(1'b1, 3'd1, 32'h0000_003C);
        chk("R2 clear", flt_en_o, 32'h0000_00C3);
        // R3: mode bits
        wr(1'b1, 3'd2, 32'h0000_0F00);
        wr(1'b1, 3'd3, 32'h0000_0300);
        chk("R3 mode", deb_sel_o, 32'h0000_0C00);
        // R4: divider keeps only low bits
        wr(1'b1, 3'd4, 32'hFFFF_FFFF);
        chk("R4 div", {18'h0, div_o}, 32'h0000_3FFF);
        // R5: undefined codes and idle strobe do nothing
        wr(1'b1, 3'd5, 32'hFFFF_FFFF);
        wr(1'b1, 3'd7, 32'h0);
        wr(1'b0, 3'd1, 32'hFFFF_FFFF);
        chk("R5 en", flt_en_o, 32'h0000_00C3);
        chk("R5 deb", deb_sel_o, 32'h0000_0C00);
        chk("R5 div", {18'h0, div_o}, 32'h0000_3FFF);

        // R7: fast mode table walk
        wr(1'b1, 3'd0, 32'hFFFF_FFFF);
        wr(1'b1, 3'd3, 32'hFFFF_FFFF);
        idle(2);
        foreach (FAST_TBL[i]) begin
            pin_i = FAST_TBL[i].din;
            @(posedge clk_i);
            @(negedge clk_i);
            chk($sformatf("R7 step%0d", i), filt_o, FAST_TBL[i].dexp);
        end

        // R6: disabled pins pass through with no register
        wr(1'b1, 3'd1, 32'h0000_FFFF);
        pin_i = 32'hFFFF_FFFF;
        #1;
        chk("R6 bypass", filt_o, 32'h0000_FFFF);
        idle(3);

        // R10: enabling on a steady input gives no transition
        wr(1'b1, 3'd0, 32'h0000_FFFF);
        chk("R10 enable", filt_o, 32'hFFFF_FFFF);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_i);
            chk("R10 steady", filt_o, 32'hFFFF_FFFF);
        end

        // R8: slow mode, DIV=1 gives ticks at write edge +4, +8
        pin_i = '0;
        idle(3);
        wr(1'b1, 3'd2, 32'hFFFF_FFFF);
        wr(1'b1, 3'd4, 32'h0000_0001);
        pin_i = 32'hFFFF_FFFF;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk_i);
            @(negedge clk_i);
            if (k == 7) chk("R8 before second tick", filt_o, 32'h0);
            if (k == 8) chk("R8 second tick", filt_o, 32'hFFFF_FFFF);
        end

        // R9: pulse between ticks, then pulse covering one tick
        for (int k = 9; k <= 26; k++) begin
            @(posedge clk_i);
            @(negedge clk_i);
            chk($sformatf("R9 edge%0d", k), filt_o, 32'hFFFF_FFFF);
            if (k == 9 || k == 16) pin_i = '0;
            if (k == 10 || k == 20) pin_i = 32'hFFFF_FFFF;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule